// File: doc/BRIEF.md
# Graphics Control Port Status Register

This block is the register file behind the control port of a raster graphics unit. Software writes 32-bit control words whose top byte selects a command. The block keeps a 32-bit status word, the display start coordinates and the vertical display range. It also derives the active display width and height from mode bits held in the status word. Every control word whose command number is below the shadow depth is also kept in a shadow entry, which can be read back through a select port.

A second input carries the drawing command stream, one word per valid cycle. A small parser tracks where each command starts. It has two states: `PS_OPCODE`, which waits for a command header, and `PS_PARAM`, which counts that command's parameter words. Transitions: `PS_OPCODE -> PS_PARAM` on a header with a nonzero parameter count. `PS_PARAM -> PS_PARAM` on each parameter word except the last. `PS_PARAM -> PS_OPCODE` on the last parameter word.

From the stream, the block picks up draw-mode, mask and texture-page settings into the status word. A vertical-blank strobe advances an odd/even field flag while interlaced output is selected. The status word is a combinational view of the registered state.

Top module: `gfx_ctrl_status`

## Requirements
- R1: Reset, and a control write with command 0x00, set the status word to 0x14802000 and clear the field flag (status bit 31).
- R2: Command 0x03 copies data bit 0 into status bit 23. Command 0x04 copies data bits 1:0 into status bits 30:29. No other status bit changes.
- R3: Command 0x05 loads display start X from data bits 9:0 and start Y from data bits 19:10. Command 0x07 loads the vertical range start from data bits 9:0 and the range end from data bits 19:10.
- R4: Command 0x08 writes status bits 22:17 with data bits 5:0 and status bit 16 with data bit 6.
- R5: Display width follows status bits 18:16: codes 0..7 give 256, 368, 320, 384, 512, 512, 640, 640. Display height follows status bits 20:19: codes 0..3 give 240, 480, 256, 480.
- R6: A stream header with opcode 0xE1 (top byte) replaces status bits 10:0 with word bits 10:0. A header with opcode 0xE6 replaces status bits 12:11 with word bits 1:0.
- R7: Each stream header is followed by a fixed number of parameter words, and parameter words are never decoded as headers. The counts are:
  - 0x00, 0xE1 and 0xE6: none
  - 0x20 to 0x23: 3
  - 0x24 to 0x27: 6
  - 0x2C to 0x2F: 8
  - 0x34 to 0x37: 8
  - 0x3C to 0x3F: 11
  - 0x40: 2
  - 0x48: 3
  - 0x60: 2
- R8: A flat textured header (opcode AND 0xF4 equals 0x24) loads status bits 8:0 from bits 8:0 of its 5th word, counting the header as the 1st. A shaded textured header (opcode AND 0xF4 equals 0x34) does the same from its 6th word.
- R9: While status bit 22 is set, each vertical-blank strobe toggles the field flag, which is read as status bit 31. One cycle after bit 22 reads clear, the flag reads 0.
- R10: A control write with command below 16 stores the whole word in the shadow entry of that number. Commands of 16 and above leave every entry unchanged. `shadow_word` shows the entry chosen by `shadow_sel`.
- R11: When a control write and a stream update land in the same cycle, the control write wins on overlapping status bits, and the stream update still applies to bits the control write does not touch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control word valid |
| ctl_word | input | 32 | Control word, command in bits 31:24 |
| draw_wr | input | 1 | Drawing stream word valid |
| draw_word | input | 32 | Drawing stream word |
| vblank_pulse | input | 1 | One-cycle vertical-blank entry strobe |
| shadow_sel | input | 4 | Shadow entry select |
| status_word | output | 32 | Status word including field flag |
| disp_x | output | 10 | Display start X |
| disp_y | output | 10 | Display start Y |
| vrange_lo | output | 10 | Vertical range start |
| vrange_hi | output | 10 | Vertical range end |
| disp_width | output | 10 | Active display width |
| disp_height | output | 9 | Active display height |
| shadow_word | output | 32 | Selected shadow entry |

## Verification
Every cycle, the assertions check these properties:
- the reset command value, the bit-23 copy and the mode-bit remap;
- field-flag toggling under interlace and its clearing without interlace;
- the width staying inside its legal set;
- the parser never holding a zero count in the parameter state and never raising two stream updates at once;
- shadow entries loading and holding.

Only the bench scenarios can show the following:
- that parameter words carrying 0xE1 or 0xE6 in their top byte are skipped;
- that the texture page comes from exactly the 5th or 6th word;
- the full width and height tables;
- the mixed-priority outcomes of simultaneous control and stream updates.

// File: rtl/gfx_cs_pkg.sv
`timescale 1ns/1ps
package gfx_cs_pkg;

    typedef enum logic {
        PS_OPCODE,
        PS_PARAM
    } parse_state_t;

    localparam logic [30:0] STATUS_RST = 31'h14802000;

    localparam logic [7:0] CC_RESET  = 8'h00;
    localparam logic [7:0] CC_BLANK  = 8'h03;
    localparam logic [7:0] CC_DMADIR = 8'h04;
    localparam logic [7:0] CC_START  = 8'h05;
    localparam logic [7:0] CC_VRANGE = 8'h07;
    localparam logic [7:0] CC_MODE   = 8'h08;

    localparam logic [7:0] DC_DRAWMODE = 8'hE1;
    localparam logic [7:0] DC_MASK     = 8'hE6;

    // number of parameter words that follow a stream header
    function automatic logic [3:0] param_count(input logic [7:0] op);
        logic [3:0] n;
        case (op) inside
            8'h02:          n = 4'd2;
            [8'h20:8'h23]:  n = 4'd3;
            [8'h24:8'h27]:  n = 4'd6;
            [8'h28:8'h2B]:  n = 4'd4;
            [8'h2C:8'h2F]:  n = 4'd8;
            [8'h30:8'h33]:  n = 4'd5;
            [8'h34:8'h37]:  n = 4'd8;
            [8'h38:8'h3B]:  n = 4'd7;
            [8'h3C:8'h3F]:  n = 4'd11;
            [8'h40:8'h43]:  n = 4'd2;
            [8'h48:8'h4F]:  n = 4'd3;
            [8'h50:8'h53]:  n = 4'd3;
            [8'h58:8'h5F]:  n = 4'd4;
            [8'h60:8'h63]:  n = 4'd2;
            [8'h64:8'h67]:  n = 4'd3;
            [8'h68:8'h6B]:  n = 4'd1;
            [8'h6C:8'h6F]:  n = 4'd2;
            [8'h70:8'h73]:  n = 4'd1;
            [8'h74:8'h77]:  n = 4'd2;
            [8'h78:8'h7B]:  n = 4'd1;
            [8'h7C:8'h7F]:  n = 4'd2;
            8'h80:          n = 4'd3;
            8'hA0:          n = 4'd2;
            8'hC0:          n = 4'd2;
            default:        n = 4'd0;
        endcase
        return n;
    endfunction

    // word index (header = 0) that carries the texture page, 0 = none
    function automatic logic [2:0] tex_slot(input logic [7:0] op);
        logic [2:0] s;
        if ((op & 8'hF4) == 8'h24)      s = 3'd4;
        else if ((op & 8'hF4) == 8'h34) s = 3'd5;
        else                            s = 3'd0;
        return s;
    endfunction

endpackage

// File: rtl/gfx_cs_cmd_stream.sv
`timescale 1ns/1ps
module gfx_cs_cmd_stream
    import gfx_cs_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       word_vld,
    input  logic [7:0] word_op,
    output logic       drawmode_we,
    output logic       mask_we,
    output logic       texpage_we
);

    parse_state_t     state_q, state_d;
    logic [CNT_W-1:0] left_q, left_d;
    logic [CNT_W-1:0] pos_q, pos_d;
    logic [2:0]       slot_q, slot_d;
    logic [CNT_W-1:0] hdr_len;

    assign hdr_len = CNT_W'(param_count(word_op));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_OPCODE;
            left_q  <= '0;
            pos_q   <= '0;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
            pos_q   <= pos_d;
            slot_q  <= slot_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        pos_d   = pos_q;
        slot_d  = slot_q;
        if (word_vld) begin
            unique case (state_q)
                PS_OPCODE: begin
                    if (hdr_len != '0) begin
                        state_d = PS_PARAM;
                        left_d  = hdr_len;
                        pos_d   = CNT_W'(1);
                        slot_d  = tex_slot(word_op);
                    end
                end
                PS_PARAM: begin
                    if (left_q == CNT_W'(1)) begin
                        state_d = PS_OPCODE;
                        left_d  = '0;
                        pos_d   = '0;
                        slot_d  = '0;
                    end else begin
                        left_d = left_q - CNT_W'(1);
                        pos_d  = pos_q + CNT_W'(1);
                    end
                end
                default: state_d = PS_OPCODE;
            endcase
        end
    end

    // outputs
    always_comb begin
        drawmode_we = 1'b0;
        mask_we     = 1'b0;
        texpage_we  = 1'b0;
        unique case (state_q)
            PS_OPCODE: begin
                drawmode_we = word_vld && (word_op == DC_DRAWMODE);
                mask_we     = word_vld && (word_op == DC_MASK);
            end
            PS_PARAM: begin
                texpage_we = word_vld && (slot_q != 3'd0) && (pos_q == CNT_W'(slot_q));
            end
            default: ;
        endcase
    end

    AST_PARAM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_PARAM) |-> (left_q != '0)) else $error("param count zero"); // R7

    AST_ONE_SIDEBAND: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drawmode_we, mask_we, texpage_we})) else $error("two stream updates"); // R8

    AST_TEX_IN_BODY: assert property (@(posedge clk) disable iff (!rst_n)
        texpage_we |=> (state_q == PS_OPCODE) || (left_q != '0)) else $error("tex outside body"); // R8

endmodule

// File: rtl/gfx_cs_mode_lut.sv
`timescale 1ns/1ps
module gfx_cs_mode_lut #(
    parameter int WID_W = 10,
    parameter int HGT_W = 9
) (
    input  logic [2:0]       hsel,
    input  logic [1:0]       vsel,
    output logic [WID_W-1:0] width,
    output logic [HGT_W-1:0] height
);

    always_comb begin
        unique case (hsel)
            3'd0:    width = WID_W'(256);
            3'd1:    width = WID_W'(368);
            3'd2:    width = WID_W'(320);
            3'd3:    width = WID_W'(384);
            3'd4,
            3'd5:    width = WID_W'(512);
            default: width = WID_W'(640);
        endcase
    end

    always_comb begin
        unique case (vsel)
            2'd0:    height = HGT_W'(240);
            2'd2:    height = HGT_W'(256);
            default: height = HGT_W'(480);
        endcase
    end

endmodule

// File: rtl/gfx_cs_shadow_file.sv
`timescale 1ns/1ps
module gfx_cs_shadow_file #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    localparam int SEL_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [7:0]        cmd,
    input  logic [WORD_W-1:0] data,
    input  logic [SEL_W-1:0]  sel,
    output logic [WORD_W-1:0] q
);

    logic [WORD_W-1:0] sh_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                sh_q[g] <= '0;
            else if (wr && (cmd == 8'(g)))
                sh_q[g] <= data;
        end

        AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && cmd == 8'(g)) |=> (sh_q[g] == $past(data))) else $error("shadow load"); // R10

        AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && cmd >= 8'(DEPTH)) |=> $stable(sh_q[g])) else $error("shadow touched"); // R10
    end

    assign q = sh_q[sel];

endmodule

// File: rtl/gfx_ctrl_status.sv
`timescale 1ns/1ps
module gfx_ctrl_status
    import gfx_cs_pkg::*;
#(
    parameter int SHADOW_N = 16,
    parameter int COORD_W  = 10,
    parameter int WID_W    = 10,
    parameter int HGT_W    = 9,
    localparam int SEL_W   = $clog2(SHADOW_N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_wr,
    input  logic [31:0]        ctl_word,
    input  logic               draw_wr,
    input  logic [31:0]        draw_word,
    input  logic               vblank_pulse,
    input  logic [SEL_W-1:0]   shadow_sel,
    output logic [31:0]        status_word,
    output logic [COORD_W-1:0] disp_x,
    output logic [COORD_W-1:0] disp_y,
    output logic [COORD_W-1:0] vrange_lo,
    output logic [COORD_W-1:0] vrange_hi,
    output logic [WID_W-1:0]   disp_width,
    output logic [HGT_W-1:0]   disp_height,
    output logic [31:0]        shadow_word
);

    localparam int FLD_HI = 2 * COORD_W - 1;

    logic [7:0]  ctl_cmd;
    logic        is_reset_cmd;
    logic [30:0] st_q, st_d;
    logic        field_q, field_d;
    logic        dm_we, mk_we, tp_we;
    logic [COORD_W-1:0] x_q, y_q, lo_q, hi_q;

    assign ctl_cmd      = ctl_word[31:24];
    assign is_reset_cmd = ctl_wr && (ctl_cmd == CC_RESET);

    gfx_cs_cmd_stream #(.CNT_W(4)) u_stream (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_vld    (draw_wr),
        .word_op     (draw_word[31:24]),
        .drawmode_we (dm_we),
        .mask_we     (mk_we),
        .texpage_we  (tp_we)
    );

    // status word: stream updates first, control writes override
    always_comb begin
        st_d = st_q;
        if (dm_we) st_d[10:0]  = draw_word[10:0];
        if (mk_we) st_d[12:11] = draw_word[1:0];
        if (tp_we) st_d[8:0]   = draw_word[8:0];
        if (ctl_wr) begin
            unique case (ctl_cmd)
                CC_RESET:  st_d = STATUS_RST;
                CC_BLANK:  st_d[23] = ctl_word[0];
                CC_DMADIR: st_d[30:29] = ctl_word[1:0];
                CC_MODE: begin
                    st_d[22:17] = ctl_word[5:0];
                    st_d[16]    = ctl_word[6];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        if (is_reset_cmd)
            field_d = 1'b0;
        else if (st_q[22])
            field_d = field_q ^ vblank_pulse;
        else
            field_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= STATUS_RST;
            field_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            field_q <= field_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q  <= '0;
            y_q  <= '0;
            lo_q <= '0;
            hi_q <= '0;
        end else if (ctl_wr) begin
            if (ctl_cmd == CC_START) begin
                x_q <= ctl_word[COORD_W-1:0];
                y_q <= ctl_word[FLD_HI:COORD_W];
            end
            if (ctl_cmd == CC_VRANGE) begin
                lo_q <= ctl_word[COORD_W-1:0];
                hi_q <= ctl_word[FLD_HI:COORD_W];
            end
        end
    end

    gfx_cs_mode_lut #(.WID_W(WID_W), .HGT_W(HGT_W)) u_lut (
        .hsel   (st_q[18:16]),
        .vsel   (st_q[20:19]),
        .width  (disp_width),
        .height (disp_height)
    );

    gfx_cs_shadow_file #(.DEPTH(SHADOW_N), .WORD_W(32)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ctl_wr),
        .cmd   (ctl_cmd),
        .data  (ctl_word),
        .sel   (shadow_sel),
        .q     (shadow_word)
    );

    assign status_word = {field_q, st_q};
    assign disp_x      = x_q;
    assign disp_y      = y_q;
    assign vrange_lo   = lo_q;
    assign vrange_hi   = hi_q;

    AST_RESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        is_reset_cmd |=> (status_word == 32'h14802000)) else $error("reset cmd"); // R1

    AST_BLANK_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_cmd == CC_BLANK) |=> (status_word[23] == $past(ctl_word[0]))) else $error("blank"); // R2

    AST_MODE_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_cmd == CC_MODE) |=>
        (status_word[22:16] == {$past(ctl_word[5:0]), $past(ctl_word[6])})) else $error("mode remap"); // R4

    AST_WIDTH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        disp_width inside {WID_W'(256), WID_W'(320), WID_W'(368), WID_W'(384), WID_W'(512), WID_W'(640)})
        else $error("width"); // R5

    AST_FIELD_PROGRESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !status_word[22] |=> !status_word[31]) else $error("field not cleared"); // R9

    AST_FIELD_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[22] && vblank_pulse && !is_reset_cmd) |=>
        (status_word[31] != $past(status_word[31]))) else $error("field toggle"); // R9

    AST_CTRL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_reset_cmd && draw_wr) |=> (status_word[12:0] == 13'h0000)) else $error("priority"); // R11

endmodule

// File: tb/gfx_ctrl_status_tb.sv
`timescale 1ns/1ps
module gfx_ctrl_status_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_word = '0;
    logic        draw_wr = 1'b0;
    logic [31:0] draw_word = '0;
    logic        vblank_pulse = 1'b0;
    logic [3:0]  sh_sel = '0;
    logic [31:0] status_word, shadow_word;
    logic [9:0]  disp_x, disp_y, vrange_lo, vrange_hi, disp_width;
    logic [8:0]  disp_height;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference state
    logic [30:0] m_st;
    logic        m_f;
    logic [9:0]  m_x, m_y, m_lo, m_hi;
    logic [31:0] m_sh [16];
    bit          m_body;
    int          m_left, m_pos, m_slot;

    logic [7:0] ctl_ops  [12] = '{8'h00, 8'h03, 8'h04, 8'h05, 8'h07, 8'h08,
                                  8'h08, 8'h01, 8'h02, 8'h0F, 8'h10, 8'hE1};
    logic [7:0] draw_ops [11] = '{8'h00, 8'h20, 8'h24, 8'h2C, 8'h34, 8'h3C,
                                  8'h40, 8'h48, 8'h60, 8'hE1, 8'hE6};

    always #2 clk = ~clk;

    gfx_ctrl_status u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_word(ctl_word),
        .draw_wr(draw_wr), .draw_word(draw_word), .vblank_pulse(vblank_pulse),
        .shadow_sel(sh_sel), .status_word(status_word), .disp_x(disp_x),
        .disp_y(disp_y), .vrange_lo(vrange_lo), .vrange_hi(vrange_hi),
        .disp_width(disp_width), .disp_height(disp_height), .shadow_word(shadow_word)
    );

    function automatic int exp_len(input logic [7:0] op); // R7 counts
        case (op)
            8'h20, 8'h21, 8'h22, 8'h23: return 3;
            8'h24, 8'h25, 8'h26, 8'h27: return 6;
            8'h2C, 8'h2D, 8'h2E, 8'h2F: return 8;
            8'h34, 8'h35, 8'h36, 8'h37: return 8;
            8'h3C, 8'h3D, 8'h3E, 8'h3F: return 11;
            8'h40, 8'h60: return 2;
            8'h48: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_slot(input logic [7:0] op); // R8
        if (op >= 8'h24 && op <= 8'h27) return 4;
        if (op >= 8'h2C && op <= 8'h2F) return 4;
        if (op >= 8'h34 && op <= 8'h37) return 5;
        if (op >= 8'h3C && op <= 8'h3F) return 5;
        return 0;
    endfunction

    function automatic logic [9:0] exp_w(input logic [2:0] s); // R5
        case (s)
            3'd0: return 10'd256; 3'd1: return 10'd368; 3'd2: return 10'd320;
            3'd3: return 10'd384; 3'd4: return 10'd512; 3'd5: return 10'd512;
            default: return 10'd640;
        endcase
    endfunction

    function automatic logic [8:0] exp_h(input logic [1:0] s); // R5
        case (s)
            2'd0: return 9'd240; 2'd1: return 9'd480; 2'd2: return 9'd256;
            default: return 9'd480;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_st = 31'h14802000; m_f = 1'b0;
        m_x = '0; m_y = '0; m_lo = '0; m_hi = '0;
        for (int i = 0; i < 16; i++) m_sh[i] = '0;
        m_body = 1'b0; m_left = 0; m_pos = 0; m_slot = 0;
    endtask

    task automatic step(input logic cw, input logic [31:0] cd, input logic dw,
                        input logic [31:0] dd, input logic vb);
        logic [30:0] n_st;
        logic        n_f;
        logic [7:0]  op, cc;
        @(negedge clk);
        ctl_wr = cw; ctl_word = cd; draw_wr = dw; draw_word = dd; vblank_pulse = vb;
        n_st = m_st;
        op = dd[31:24];
        cc = cd[31:24];
        if (dw) begin
            if (!m_body) begin
                if (op == 8'hE1) n_st[10:0] = dd[10:0];
                if (op == 8'hE6) n_st[12:11] = dd[1:0];
                if (exp_len(op) != 0) begin
                    m_body = 1'b1; m_left = exp_len(op); m_pos = 1; m_slot = exp_slot(op);
                end
            end else begin
                if (m_slot != 0 && m_pos == m_slot) n_st[8:0] = dd[8:0];
                if (m_left == 1) begin m_body = 1'b0; m_left = 0; m_pos = 0; m_slot = 0; end
                else begin m_left--; m_pos++; end
            end
        end
        if (cw) begin
            case (cc)
                8'h00: n_st = 31'h14802000;
                8'h03: n_st[23] = cd[0];
                8'h04: n_st[30:29] = cd[1:0];
                8'h05: begin m_x = cd[9:0]; m_y = cd[19:10]; end
                8'h07: begin m_lo = cd[9:0]; m_hi = cd[19:10]; end
                8'h08: begin n_st[22:17] = cd[5:0]; n_st[16] = cd[6]; end
                default: ;
            endcase
            if (cc < 8'd16) m_sh[cc[3:0]] = cd;
        end
        if (cw && cc == 8'h00) n_f = 1'b0;
        else if (m_st[22])     n_f = m_f ^ vb;
        else                   n_f = 1'b0;
        @(posedge clk);
        #1;
        m_st = n_st; m_f = n_f;
        chk("R2 status word", status_word, {m_f, m_st});
        chk("R3 start/range", {6'd0, disp_y, disp_x, vrange_hi[5:0]}, {6'd0, m_y, m_x, m_hi[5:0]});
        chk("R3 range lo", {22'd0, vrange_lo}, {22'd0, m_lo});
        chk("R5 size", {13'd0, disp_height, disp_width}, {13'd0, exp_h(m_st[20:19]), exp_w(m_st[18:16])});
        chk("R10 shadow", shadow_word, m_sh[sh_sel]);
    endtask

    task automatic idle(); step(1'b0, '0, 1'b0, '0, 1'b0); endtask
    task automatic cw(input logic [31:0] d); step(1'b1, d, 1'b0, '0, 1'b0); endtask
    task automatic dw(input logic [31:0] d); step(1'b0, '0, 1'b1, d, 1'b0); endtask

    initial begin
        repeat (1000000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R1..: actual hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 reset status", status_word, 32'h14802000);
        chk("R5 reset width", {22'd0, disp_width}, 32'd256);
        chk("R5 reset height", {23'd0, disp_height}, 32'd240);

        // R4 / R5 remap
        cw(32'h0800007F);
        chk("R4 remap all", status_word, 32'h14FF2000);
        chk("R5 width 7", {22'd0, disp_width}, 32'd640);
        chk("R5 height 3", {23'd0, disp_height}, 32'd480);
        cw(32'h08000041);
        chk("R4 remap 0x41", status_word, 32'h14832000);
        chk("R5 width 3", {22'd0, disp_width}, 32'd384);

        // R9 field flag
        cw(32'h08000020);
        chk("R4 interlace bit", status_word, 32'h14C02000);
        step(1'b0, '0, 1'b0, '0, 1'b1);
        chk("R9 field toggles on", {31'd0, status_word[31]}, 32'd1);
        idle();
        chk("R9 field holds", {31'd0, status_word[31]}, 32'd1);
        step(1'b0, '0, 1'b0, '0, 1'b1);
        chk("R9 field toggles off", {31'd0, status_word[31]}, 32'd0);
        step(1'b0, '0, 1'b0, '0, 1'b1);
        cw(32'h08000000);
        idle();
        chk("R9 field cleared without interlace", {31'd0, status_word[31]}, 32'd0);
        step(1'b0, '0, 1'b0, '0, 1'b1);
        chk("R9 no toggle progressive", {31'd0, status_word[31]}, 32'd0);

        // R7 / R8 stream parsing
        cw(32'h00000000);
        dw(32'h24000000);
        dw(32'hE6000003);
        dw(32'h00000000);
        dw(32'h00000000);
        dw(32'h000001A5);
        dw(32'h00000000);
        dw(32'h00000000);
        chk("R8 flat tex / R7 params skipped", status_word, 32'h148021A5);
        dw(32'hE6000001);
        chk("R7 next header decoded", status_word, 32'h148029A5);
        dw(32'h3C000000);
        for (int i = 1; i <= 11; i++) dw(i == 5 ? 32'h000000F3 : 32'hE1FFFFFF);
        chk("R8 shaded tex 6th word", status_word, 32'h148028F3);

        // R6 draw mode / mask
        dw(32'hE1ABCFFF);
        chk("R6 draw mode", status_word, 32'h14802FFF);
        dw(32'hE6000002);
        chk("R6 mask", status_word, 32'h148037FF);

        // R11 priority
        step(1'b1, 32'h00000000, 1'b1, 32'hE10007FF, 1'b0);
        chk("R11 reset beats draw mode", status_word, 32'h14802000);
        step(1'b1, 32'h03000000, 1'b1, 32'hE6000001, 1'b0);
        chk("R11 disjoint bits both apply", status_word, 32'h14002800);

        // R2 DMA direction
        cw(32'h04000003);
        chk("R2 dma dir", status_word, 32'h74002800);

        // R3 coordinates
        cw(32'h050AA955);
        chk("R3 start x", {22'd0, disp_x}, 32'h155);
        chk("R3 start y", {22'd0, disp_y}, 32'h2AA);
        cw(32'h07040010);
        chk("R3 range lo", {22'd0, vrange_lo}, 32'h010);
        chk("R3 range hi", {22'd0, vrange_hi}, 32'h100);

        // R10 shadow
        sh_sel = 4'd15;
        cw(32'h0F123456);
        chk("R10 shadow store", shadow_word, 32'h0F123456);
        cw(32'h10ABCDEF);
        chk("R10 cmd 16 ignored", shadow_word, 32'h0F123456);
        sh_sel = 4'd5;
        #1;
        chk("R10 shadow entry 5", shadow_word, 32'h050AA955);

        // R1 reset command
        cw(32'h00000000);
        chk("R1 reset command", status_word, 32'h14802000);

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            logic        rcw, rdw, rvb;
            logic [31:0] rcd, rdd;
            rcw = ($urandom % 3) == 0;
            rcd = {ctl_ops[$urandom % 12], 24'($urandom)};
            if (rcd[31:24] == 8'h00 && ($urandom % 4) != 0) rcd[31:24] = 8'h08;
            rdw = ($urandom % 2) == 0;
            rdd = m_body ? 32'($urandom) : {draw_ops[$urandom % 11], 24'($urandom)};
            rvb = ($urandom % 4) == 0;
            sh_sel = 4'($urandom);
            step(rcw, rcd, rdw, rdd, rvb);
        end

        idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule